// File: doc/BRIEF.md
# SERDES Lane Power Sequencer

This block walks a SERDES lane through its power-up and power-down sequences on its own. It reaches the lane's management registers through a single request/acknowledge access port. In a typical system an MDIO master sits behind that port. A pulse on the up command runs three steps: request the PLL clock, assert the lane reset, and enter power state P0. A pulse on the down command runs a different set of three steps: enter power state P3, release the clock request, and release the lane reset.

Each step does the same things in order. It reads the configuration register and changes only the target field. It writes the full 16-bit word back. It then reads the status register until the same field matches, with a fixed time gap between reads and a fixed limit on the number of reads. If a step runs out of reads, the rest of the sequence is skipped and the failing step is reported.

Top module: `serdes_pwr_seq`

## Requirements
- R1: An up command drives the configuration register at offset 0xB through three steps in this order. First it sets bit 0 and waits until status bit 0 reads 1. Next it sets bit 2 and waits until status bit 2 reads 1. Last it writes 0 (P0) into bits 6:4 and waits until status bits 6:4 read 0.
- R2: A down command runs these steps in this order. First it writes 3 (P3) into bits 6:4 and waits until status bits 6:4 read 3. Next it clears bit 0 and waits until status bit 0 reads 0. Last it clears bit 2 and waits until status bit 2 reads 0.
- R3: Each step reads offset 0xB and then writes the full 16-bit word back to offset 0xB. Only the step's field changes; every other bit keeps the value that was read.
- R4: Status is read at offset 0x5. Only the step's field is compared, so the other status bits have no effect.
- R5: A step makes at most MAX_POLLS status reads. If none of them match, the sequence ends with err_o = 1 and err_step_o set to the step code. The codes are: clock request 1, lane reset 2, P0 3, P3 4, clock release 5, reset release 6.
- R6: Consecutive status reads within one step are at least CLK_FREQ_HZ/1e6 × POLL_GAP_US clock cycles apart.
- R7: A timeout aborts the sequence, and no later step issues any access.
- R8: If the port address is 0 when a command arrives, done_o pulses in the next cycle. No access is made and err_o stays 0.
- R9: Commands that arrive while busy_o is 1 are ignored. No extra sequence and no extra done pulse follow.
- R10: done_o is a one-cycle pulse at the end of every sequence, whether it succeeded or failed. err_o and err_step_o keep their values until the next accepted command clears them. A successful sequence leaves both at 0.
- R11: A request holds its address, direction and data steady until acknowledged. Every access uses the port address captured when the command was accepted.
- R12: After reset the block is idle. busy_o, done_o, err_o and acc_req_o are 0, and err_step_o is 0.
- R13: If up and down commands arrive in the same cycle, the up sequence runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| up_cmd_i | input | 1 | Start power-up sequence |
| down_cmd_i | input | 1 | Start power-down sequence |
| phy_addr_i | input | 5 | Management port address of the lane; 0 disables access |
| acc_req_o | output | 1 | Access request, held until acknowledged |
| acc_we_o | output | 1 | 1 = write, 0 = read |
| acc_phy_o | output | 5 | Port address of the access |
| acc_reg_o | output | 5 | Register offset of the access |
| acc_wdata_o | output | 16 | Write data |
| acc_ack_i | input | 1 | Access complete; read data valid |
| acc_rdata_i | input | 16 | Read data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| err_o | output | 1 | Last sequence timed out |
| err_step_o | output | 3 | Code of the step that timed out |

## Verification
The bench builds the block with CLK_FREQ_HZ = 500000, POLL_GAP_US = 8 and MAX_POLLS = 10. With these values the gap between polls is 4 cycles instead of 400, so a full run of ten failed polls finishes in well under a hundred cycles. That makes first-step and mid-sequence timeouts cheap to exercise next to the normal up and down runs. The register model can lag its status by a set number of reads and can hold chosen status bits stuck. It also sets an unrelated status bit, which exercises the masked comparison.

// File: rtl/serdes_pwr_pkg.sv
package serdes_pwr_pkg;
  localparam int unsigned RDW = 16;
  localparam int unsigned RAW = 5;

  localparam logic [RAW-1:0] CFG_OFS = 5'h0B;
  localparam logic [RAW-1:0] STS_OFS = 5'h05;

  localparam logic [RDW-1:0] CLK_BIT = 16'h0001;
  localparam logic [RDW-1:0] RST_BIT = 16'h0004;
  localparam int unsigned    PWR_LSB = 4;
  localparam logic [RDW-1:0] PWR_FLD = 16'h0007 << PWR_LSB;
  localparam logic [RDW-1:0] PWR_P0  = 16'h0000 << PWR_LSB;
  localparam logic [RDW-1:0] PWR_P3  = 16'h0003 << PWR_LSB;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_CFG, ST_WR_CFG, ST_RD_STS, ST_WAIT, ST_DONE
  } state_e;

  // step index + 1 is the reported error code
  typedef enum logic [2:0] {
    STEP_CLK_REQ  = 3'd0,
    STEP_LANE_RST = 3'd1,
    STEP_PWR_P0   = 3'd2,
    STEP_PWR_P3   = 3'd3,
    STEP_CLK_REL  = 3'd4,
    STEP_RST_REL  = 3'd5
  } step_e;

  typedef struct packed {
    logic [RDW-1:0] mask;
    logic [RDW-1:0] val;
  } field_t;

  function automatic field_t step_field(step_e s);
    field_t f;
    case (s)
      STEP_CLK_REQ:  f = '{mask: CLK_BIT, val: CLK_BIT};
      STEP_LANE_RST: f = '{mask: RST_BIT, val: RST_BIT};
      STEP_PWR_P0:   f = '{mask: PWR_FLD, val: PWR_P0};
      STEP_PWR_P3:   f = '{mask: PWR_FLD, val: PWR_P3};
      STEP_CLK_REL:  f = '{mask: CLK_BIT, val: '0};
      STEP_RST_REL:  f = '{mask: RST_BIT, val: '0};
      default:       f = '{mask: '0, val: '0};
    endcase
    return f;
  endfunction
endpackage

// File: rtl/serdes_step_unit.sv
module serdes_step_unit
  import serdes_pwr_pkg::*;
(
  input  step_e          step_i,
  input  logic [RDW-1:0] rd_i,
  output logic [RDW-1:0] cfg_wr_o,
  output logic           sts_ok_o
);
  field_t fld;

  always_comb begin
    fld      = step_field(step_i);
    cfg_wr_o = (rd_i & ~fld.mask) | (fld.val & fld.mask);
    sts_ok_o = ((rd_i ^ fld.val) & fld.mask) == '0;
  end
endmodule

// File: rtl/serdes_retry_cnt.sv
module serdes_retry_cnt #(
  parameter int unsigned MAX_TRIES = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int unsigned CW = $clog2(MAX_TRIES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  // high while the read in flight is the final permitted one
  assign last_o = (cnt_q == CW'(MAX_TRIES - 1));
endmodule

// File: rtl/serdes_delay_timer.sv
module serdes_delay_timer #(
  parameter int unsigned CYCLES = 400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic expired_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == CW'(1));
endmodule

// File: rtl/serdes_pwr_seq.sv
module serdes_pwr_seq
  import serdes_pwr_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ = 50_000_000,
  parameter int unsigned POLL_GAP_US = 8,
  parameter int unsigned MAX_POLLS   = 10
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        up_cmd_i,
  input  logic        down_cmd_i,
  input  logic [4:0]  phy_addr_i,
  output logic        acc_req_o,
  output logic        acc_we_o,
  output logic [4:0]  acc_phy_o,
  output logic [4:0]  acc_reg_o,
  output logic [15:0] acc_wdata_o,
  input  logic        acc_ack_i,
  input  logic [15:0] acc_rdata_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        err_o,
  output logic [2:0]  err_step_o
);
  localparam int unsigned GAP_RAW   = (CLK_FREQ_HZ / 1000) * POLL_GAP_US / 1000;
  localparam int unsigned DELAY_CYC = (GAP_RAW < 1) ? 1 : GAP_RAW;

  state_e         state_q;
  step_e          step_q, last_q;
  logic [RAW-1:0] addr_q;
  logic [RDW-1:0] wdata_q;
  logic           err_q;
  logic [2:0]     err_step_q;

  logic [RDW-1:0] cfg_wr;
  logic           sts_ok;
  logic           poll_last;
  logic           timer_exp;
  logic           sts_ack, poll_miss, poll_retry, wr_ack;

  serdes_step_unit u_step (
    .step_i   (step_q),
    .rd_i     (acc_rdata_i),
    .cfg_wr_o (cfg_wr),
    .sts_ok_o (sts_ok)
  );

  assign sts_ack    = (state_q == ST_RD_STS) && acc_ack_i;
  assign poll_miss  = sts_ack && !sts_ok;
  assign poll_retry = poll_miss && !poll_last;
  assign wr_ack     = (state_q == ST_WR_CFG) && acc_ack_i;

  serdes_retry_cnt #(.MAX_TRIES(MAX_POLLS)) u_retry (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (wr_ack),
    .inc_i  (poll_retry),
    .last_o (poll_last)
  );

  serdes_delay_timer #(.CYCLES(DELAY_CYC)) u_gap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (poll_retry),
    .expired_o (timer_exp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      step_q     <= STEP_CLK_REQ;
      last_q     <= STEP_PWR_P0;
      addr_q     <= '0;
      wdata_q    <= '0;
      err_q      <= 1'b0;
      err_step_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (up_cmd_i || down_cmd_i) begin
            err_q      <= 1'b0;
            err_step_q <= '0;
            addr_q     <= phy_addr_i;
            step_q     <= up_cmd_i ? STEP_CLK_REQ : STEP_PWR_P3;
            last_q     <= up_cmd_i ? STEP_PWR_P0  : STEP_RST_REL;
            state_q    <= (phy_addr_i == '0) ? ST_DONE : ST_RD_CFG;
          end
        end
        ST_RD_CFG: begin
          if (acc_ack_i) begin
            wdata_q <= cfg_wr;
            state_q <= ST_WR_CFG;
          end
        end
        ST_WR_CFG: begin
          if (acc_ack_i) state_q <= ST_RD_STS;
        end
        ST_RD_STS: begin
          if (acc_ack_i) begin
            if (sts_ok) begin
              if (step_q == last_q) state_q <= ST_DONE;
              else begin
                step_q  <= step_e'(step_q + 3'd1);
                state_q <= ST_RD_CFG;
              end
            end else if (poll_last) begin
              err_q      <= 1'b1;
              err_step_q <= step_q + 3'd1;
              state_q    <= ST_DONE;
            end else begin
              state_q <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (timer_exp) state_q <= ST_RD_STS;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    acc_req_o   = (state_q == ST_RD_CFG) || (state_q == ST_WR_CFG) || (state_q == ST_RD_STS);
    acc_we_o    = (state_q == ST_WR_CFG);
    acc_reg_o   = (state_q == ST_RD_STS) ? STS_OFS : CFG_OFS;
    acc_phy_o   = addr_q;
    acc_wdata_o = wdata_q;
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_DONE);
  assign err_o      = err_q;
  assign err_step_o = err_step_q;
endmodule

// File: rtl/serdes_pwr_seq_chk.sv
module serdes_pwr_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        up_cmd_i,
  input logic        down_cmd_i,
  input logic [4:0]  phy_addr_i,
  input logic        acc_req_o,
  input logic        acc_we_o,
  input logic [4:0]  acc_phy_o,
  input logic [4:0]  acc_reg_o,
  input logic [15:0] acc_wdata_o,
  input logic        acc_ack_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o,
  input logic [2:0]  err_step_o
);
  assert_req_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_req_o && !acc_ack_i) |=> (acc_req_o && $stable(acc_we_o) && $stable(acc_reg_o)
                                  && $stable(acc_wdata_o) && $stable(acc_phy_o)));

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_err_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (!err_o && err_step_o == 3'd0));

  assert_err_code_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (err_step_o >= 3'd1 && err_step_o <= 3'd6));

  assert_idle_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !acc_req_o);

  assert_zero_addr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && (up_cmd_i || down_cmd_i) && phy_addr_i == 5'd0) |=> (done_o && !acc_req_o));

  assert_write_target_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_req_o && acc_we_o) |-> (acc_reg_o == 5'h0B));

  assert_no_access_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !acc_req_o);
endmodule

bind serdes_pwr_seq serdes_pwr_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .up_cmd_i    (up_cmd_i),
  .down_cmd_i  (down_cmd_i),
  .phy_addr_i  (phy_addr_i),
  .acc_req_o   (acc_req_o),
  .acc_we_o    (acc_we_o),
  .acc_phy_o   (acc_phy_o),
  .acc_reg_o   (acc_reg_o),
  .acc_wdata_o (acc_wdata_o),
  .acc_ack_i   (acc_ack_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .err_step_o  (err_step_o)
);

// File: tb/serdes_pwr_seq_tb.sv
module serdes_pwr_seq_tb;
  localparam int unsigned FREQ  = 500_000;
  localparam int unsigned GAPUS = 8;
  localparam int unsigned POLLS = 10;
  localparam int unsigned DELAY = FREQ / 1000 * GAPUS / 1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        up_cmd = 1'b0, down_cmd = 1'b0;
  logic [4:0]  phy_addr = 5'h15;
  logic        acc_req, acc_we, acc_ack;
  logic [4:0]  acc_phy, acc_reg;
  logic [15:0] acc_wdata, acc_rdata;
  logic        busy, done, err;
  logic [2:0]  err_step;

  always #10 clk = ~clk;

  serdes_pwr_seq #(.CLK_FREQ_HZ(FREQ), .POLL_GAP_US(GAPUS), .MAX_POLLS(POLLS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .up_cmd_i(up_cmd), .down_cmd_i(down_cmd),
    .phy_addr_i(phy_addr), .acc_req_o(acc_req), .acc_we_o(acc_we), .acc_phy_o(acc_phy),
    .acc_reg_o(acc_reg), .acc_wdata_o(acc_wdata), .acc_ack_i(acc_ack),
    .acc_rdata_i(acc_rdata), .busy_o(busy), .done_o(done), .err_o(err),
    .err_step_o(err_step)
  );

  // register bank model, controlled through ld_* from the tasks
  logic        ld_go = 1'b0;
  logic [15:0] ld_cfg = '0, ld_stuck = '0;
  int          ld_lag = 0;
  logic [4:0]  exp_addr = 5'h15;

  logic [15:0] cfg, sts;
  logic [15:0] wlog [8];
  int pend, wcnt, rcfg, rsts, bad, cyc, last_sts, step_reads, min_gap, dcnt;

  initial begin
    acc_ack = 1'b0; acc_rdata = '0; cfg = '0; sts = '0; pend = 0; wcnt = 0;
    rcfg = 0; rsts = 0; bad = 0; cyc = 0; last_sts = 0; step_reads = 0; min_gap = 1000;
    for (int i = 0; i < 8; i++) wlog[i] = '0;
  end

  always @(posedge clk) begin
    logic [15:0] nsts;
    cyc <= cyc + 1;
    if (ld_go) begin
      cfg <= ld_cfg; sts <= ld_cfg; pend <= 0; wcnt <= 0; rcfg <= 0; rsts <= 0;
      bad <= 0; step_reads <= 0; min_gap <= 1000; acc_ack <= 1'b0;
    end else if (acc_ack) begin
      acc_ack <= 1'b0;
    end else if (acc_req) begin
      acc_ack <= 1'b1;
      if (acc_phy != exp_addr) bad <= bad + 1;
      if (acc_we) begin
        if (acc_reg != 5'h0B) bad <= bad + 1;
        cfg <= acc_wdata;
        if (wcnt < 8) wlog[wcnt] <= acc_wdata;
        wcnt <= wcnt + 1; pend <= ld_lag; step_reads <= 0;
      end else if (acc_reg == 5'h0B) begin
        acc_rdata <= cfg; rcfg <= rcfg + 1;
      end else if (acc_reg == 5'h05) begin
        nsts = (pend == 0) ? ((cfg & ~ld_stuck) | (sts & ld_stuck)) : sts;
        sts <= nsts;
        acc_rdata <= nsts | 16'h0800;   // unrelated status bit
        if (pend > 0) pend <= pend - 1;
        rsts <= rsts + 1; step_reads <= step_reads + 1;
        if (step_reads > 0 && (cyc - last_sts) < min_gap) min_gap <= cyc - last_sts;
        last_sts <= cyc;
      end else begin
        bad <= bad + 1;
      end
    end
  end

  always @(negedge clk) if (done) dcnt <= dcnt + 1;
  initial dcnt = 0;

  int n_chk = 0, n_fail = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic load(logic [15:0] c, int lag, logic [15:0] stuck);
    @(negedge clk);
    ld_cfg = c; ld_lag = lag; ld_stuck = stuck; ld_go = 1'b1;
    @(negedge clk);
    ld_go = 1'b0;
  endtask

  task automatic cmd(logic u, logic d);
    @(negedge clk);
    up_cmd = u; down_cmd = d;
    @(negedge clk);
    up_cmd = 1'b0; down_cmd = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk("R10 done seen", {31'd0, done}, 1);
    @(negedge clk);
    chk("R10 done one cycle", {31'd0, done}, 0);
  endtask

  task automatic t_reset();
    chk("R12 busy", {31'd0, busy}, 0);
    chk("R12 done", {31'd0, done}, 0);
    chk("R12 err", {31'd0, err}, 0);
    chk("R12 err_step", {29'd0, err_step}, 0);
    chk("R12 req", {31'd0, acc_req}, 0);
  endtask

  task automatic t_powerup();
    load(16'hA338, 2, 16'h0000);
    cmd(1, 0);
    wait_done();
    chk("R1 write count", wcnt, 3);
    chk("R1 R3 clk req write", {16'd0, wlog[0]}, 32'hA339);
    chk("R1 R3 lane reset write", {16'd0, wlog[1]}, 32'hA33D);
    chk("R1 R3 P0 write", {16'd0, wlog[2]}, 32'hA30D);
    chk("R3 cfg reads", rcfg, 3);
    chk("R4 status reads with noise bit", rsts, 9);
    chk("R10 no error", {31'd0, err}, 0);
    chk("R10 err_step zero", {29'd0, err_step}, 0);
    chk("R11 address and offsets", bad, 0);
  endtask

  task automatic t_powerdown();
    load(16'hA30D, 2, 16'h0000);
    cmd(0, 1);
    wait_done();
    chk("R2 write count", wcnt, 3);
    chk("R2 P3 write", {16'd0, wlog[0]}, 32'hA33D);
    chk("R2 clk release write", {16'd0, wlog[1]}, 32'hA33C);
    chk("R2 reset release write", {16'd0, wlog[2]}, 32'hA338);
    chk("R2 no error", {31'd0, err}, 0);
    chk("R11 address and offsets", bad, 0);
  endtask

  task automatic t_timeout_first();
    load(16'h0000, 0, 16'hFFFF);
    cmd(1, 0);
    wait_done();
    chk("R5 err", {31'd0, err}, 1);
    chk("R5 err_step clk req", {29'd0, err_step}, 1);
    chk("R5 poll budget", rsts, POLLS);
    chk("R7 no later write", wcnt, 1);
    chk("R6 poll gap", {31'd0, (min_gap >= DELAY)}, 1);
  endtask

  task automatic t_timeout_mid();
    load(16'h0005, 2, 16'h0001);
    cmd(0, 1);
    wait_done();
    chk("R5 err mid", {31'd0, err}, 1);
    chk("R5 err_step clk release", {29'd0, err_step}, 5);
    chk("R7 aborted after step", wcnt, 2);
    chk("R7 status reads", rsts, 3 + POLLS);
    repeat (5) @(negedge clk);
    chk("R10 err held", {31'd0, err}, 1);
    load(16'h0000, 0, 16'h0000);
    cmd(1, 0);
    chk("R10 err cleared on accept", {31'd0, err}, 0);
    wait_done();
    chk("R10 err stays clear", {31'd0, err}, 0);
  endtask

  task automatic t_zero_addr();
    phy_addr = 5'd0; exp_addr = 5'd0;
    load(16'h0030, 0, 16'h0000);
    cmd(1, 0);
    chk("R8 done next cycle", {31'd0, done}, 1);
    @(negedge clk);
    chk("R8 no accesses", wcnt + rcfg + rsts, 0);
    chk("R8 no error", {31'd0, err}, 0);
    phy_addr = 5'h15; exp_addr = 5'h15;
  endtask

  task automatic t_busy_ignore();
    int d0;
    load(16'h0030, 2, 16'h0000);
    cmd(1, 0);
    repeat (3) @(negedge clk);
    cmd(0, 1);
    wait_done();
    d0 = dcnt;
    chk("R9 up ran to end", {16'd0, cfg}, 32'h0005);
    repeat (20) @(negedge clk);
    chk("R9 no extra sequence", {31'd0, busy}, 0);
    chk("R9 no extra writes", wcnt, 3);
    chk("R9 no extra done", dcnt, d0);
  endtask

  task automatic t_both();
    load(16'h0030, 0, 16'h0000);
    cmd(1, 1);
    wait_done();
    chk("R13 up first write", {16'd0, wlog[0]}, 32'h0031);
    chk("R13 up final", {16'd0, cfg}, 32'h0005);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_powerup();
    t_powerdown();
    t_timeout_first();
    t_timeout_mid();
    t_zero_addr();
    t_busy_ignore();
    t_both();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule